// File: doc/BRIEF.md
# Reverse-Subtract Skip-On-Borrow Processor Core

This core runs a machine with a single instruction and an accumulator. Every instruction word names one memory address. Executing it takes the word at that address and subtracts the accumulator from it. The difference goes back to the same address and also becomes the new accumulator. If the subtraction needed a borrow, the core skips over the following instruction. Otherwise it moves on to the next one.

The program counter sits behind address 0 and the accumulator sits behind address 1. An instruction that targets address 0 computes a jump, and one that targets address 1 clears the accumulator. Neither of those two addresses reaches the external memory port. Instructions are always fetched through that port, even when the program counter holds 0 or 1.

Memory is a single synchronous port, and read data returns one cycle after the address is driven. The program counter starts at a parameter value after reset. The core stops for good when it fetches an all-ones word, and it stays stopped until the next reset.

Top module: `rssb_core`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `halted` is 0, `mem_we` is 0 and `mem_addr` equals START_PC. The accumulator resets to 0.
- R2: Each instruction takes four cycles. In the first cycle `mem_addr` is the program counter. In the second cycle `mem_addr` is the operand address m, which is the low ADDR_W bits of the fetched word. The third cycle is write-back and the fourth updates the program counter.
- R3: For m >= 2, the write-back cycle drives `mem_we`=1, `mem_addr`=m and `mem_wdata` = (Mem[m] - ACC) mod 2^DATA_W. The same value becomes the accumulator.
- R4: The borrow is the unsigned comparison Mem[m] < ACC over the full word. For m != 0 the next fetch address is PC+2 when the borrow is set and PC+1 when it is clear, both modulo 2^ADDR_W.
- R5: Operand address 0 reads as the PC of the executing instruction. The low ADDR_W bits of the difference become the next fetch address, and this overrides the increment or skip. No external write takes place.
- R6: Operand address 1 reads as the accumulator. The result is 0 with no borrow, so the accumulator is cleared. No external write takes place.
- R7: A fetched word of all ones sets `halted` in the third cycle of that instruction. From then on `halted` stays 1 and no write occurs until reset.
- R8: Three consecutive instructions on the same location m >= 2 leave both that location and the accumulator at 0, whatever their starting values.
- R9: `mem_we` is asserted only in a write-back cycle, and only with `mem_addr` >= 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | ADDR_W | Memory word address |
| mem_we | output | 1 | Write strobe for the current address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data for the address of the previous cycle |
| halted | output | 1 | Core has stopped on an all-ones word |

## Verification
Each instruction has a fixed four-cycle timing from its fetch:
- The fetch address is due in cycle 0.
- The operand address is due in cycle 1.
- The write, or `halted` for a stop word, is due in cycle 2.
- The updated program counter shows up as the fetch address in cycle 4, the next instruction's cycle 0.

The bench runs a reference model in lockstep with the core and samples on each falling edge. Every check is tied to the cycle offset where its result is due, so a late or early output mismatches. After the stop, the full memory image is compared with the model's copy.

// File: rtl/rssb_pkg.sv
package rssb_pkg;

  typedef enum logic [2:0] {
    ST_FETCH      = 3'd0,
    ST_READ_OPND  = 3'd1,
    ST_WRITE_BACK = 3'd2,
    ST_NEXT_PC    = 3'd3,
    ST_HALT       = 3'd4
  } rssb_state_e;

  localparam int unsigned PC_ALIAS  = 0;
  localparam int unsigned ACC_ALIAS = 1;

endpackage

// File: rtl/rssb_seq.sv
module rssb_seq
  import rssb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        halt_word,
  output rssb_state_e state_q,
  output logic        fetch_evt,
  output logic        rdop_evt,
  output logic        wb_evt,
  output logic        npc_evt,
  output logic        halt_evt
);

  rssb_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FETCH:      state_d = ST_READ_OPND;
      ST_READ_OPND:  state_d = halt_word ? ST_HALT : ST_WRITE_BACK;
      ST_WRITE_BACK: state_d = ST_NEXT_PC;
      ST_NEXT_PC:    state_d = ST_FETCH;
      ST_HALT:       state_d = ST_HALT;
      default:       state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_FETCH;
    else        state_q <= state_d;
  end

  assign fetch_evt = (state_q == ST_FETCH);
  assign rdop_evt  = (state_q == ST_READ_OPND);
  assign wb_evt    = (state_q == ST_WRITE_BACK);
  assign npc_evt   = (state_q == ST_NEXT_PC);
  assign halt_evt  = rdop_evt && halt_word;

endmodule

// File: rtl/rssb_alu.sv
module rssb_alu #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] minuend,
  input  logic [DATA_W-1:0] subtrahend,
  output logic [DATA_W-1:0] diff,
  output logic              borrow
);

  function automatic logic [DATA_W-1:0] rev_sub(input logic [DATA_W-1:0] m,
                                                input logic [DATA_W-1:0] a);
    return m - a;
  endfunction

  function automatic logic borrow_of(input logic [DATA_W-1:0] m,
                                     input logic [DATA_W-1:0] a);
    logic [DATA_W:0] wide;
    wide = {1'b0, m} - {1'b0, a};
    return wide[DATA_W];
  endfunction

  assign diff   = rev_sub(minuend, subtrahend);
  assign borrow = borrow_of(minuend, subtrahend);

endmodule

// File: rtl/rssb_pc_step.sv
module rssb_pc_step #(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic              borrow,
  input  logic              jump,
  input  logic [ADDR_W-1:0] jump_target,
  output logic [ADDR_W-1:0] pc_next
);

  function automatic logic [ADDR_W-1:0] seq_step(input logic [ADDR_W-1:0] p,
                                                 input logic b);
    return p + (b ? ADDR_W'(2) : ADDR_W'(1));
  endfunction

  assign pc_next = jump ? jump_target : seq_step(pc, borrow);

endmodule

// File: rtl/rssb_regs.sv
module rssb_regs #(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 12,
  parameter int START_PC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_opnd,
  input  logic [ADDR_W-1:0] opnd_d,
  input  logic              ld_result,
  input  logic [DATA_W-1:0] result_d,
  input  logic              borrow_d,
  input  logic              ld_pc,
  input  logic [ADDR_W-1:0] pc_d,
  output logic [ADDR_W-1:0] pc_q,
  output logic [DATA_W-1:0] acc_q,
  output logic [ADDR_W-1:0] opnd_q,
  output logic              borrow_q
);

  localparam logic [ADDR_W-1:0] PC_RESET = ADDR_W'(START_PC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= PC_RESET;
      acc_q    <= '0;
      opnd_q   <= '0;
      borrow_q <= 1'b0;
    end else begin
      if (ld_opnd) opnd_q <= opnd_d;
      if (ld_result) begin
        acc_q    <= result_d;
        borrow_q <= borrow_d;
      end
      if (ld_pc) pc_q <= pc_d;
    end
  end

endmodule

// File: rtl/rssb_core.sv
module rssb_core
  import rssb_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 12,
  parameter int START_PC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              halted
);

  localparam logic [DATA_W-1:0] HALT_WORD = {DATA_W{1'b1}};
  localparam logic [ADDR_W-1:0] PC_ADDR   = ADDR_W'(PC_ALIAS);
  localparam logic [ADDR_W-1:0] ACC_ADDR  = ADDR_W'(ACC_ALIAS);

  rssb_state_e       state_q;
  logic              fetch_evt, rdop_evt, wb_evt, npc_evt, halt_evt;
  logic              halt_word;
  logic [ADDR_W-1:0] instr_opnd;
  logic [ADDR_W-1:0] pc_q, opnd_q, pc_next;
  logic [DATA_W-1:0] acc_q;
  logic              borrow_q;
  logic              opnd_is_pc, opnd_is_acc, opnd_external;
  logic [DATA_W-1:0] pc_word, operand_val, diff;
  logic              borrow;
  logic              jump_evt;

  assign halt_word  = (mem_rdata == HALT_WORD);
  assign instr_opnd = mem_rdata[ADDR_W-1:0];

  generate
    if (DATA_W > ADDR_W) begin : g_pc_widen
      assign pc_word = {{(DATA_W-ADDR_W){1'b0}}, pc_q};
    end else begin : g_pc_same
      assign pc_word = pc_q[DATA_W-1:0];
    end
  endgenerate

  rssb_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .halt_word (halt_word),
    .state_q   (state_q),
    .fetch_evt (fetch_evt),
    .rdop_evt  (rdop_evt),
    .wb_evt    (wb_evt),
    .npc_evt   (npc_evt),
    .halt_evt  (halt_evt)
  );

  assign opnd_is_pc    = (opnd_q == PC_ADDR);
  assign opnd_is_acc   = (opnd_q == ACC_ADDR);
  assign opnd_external = !opnd_is_pc && !opnd_is_acc;

  always_comb begin
    if (opnd_is_pc)       operand_val = pc_word;
    else if (opnd_is_acc) operand_val = acc_q;
    else                  operand_val = mem_rdata;
  end

  rssb_alu #(.DATA_W(DATA_W)) u_alu (
    .minuend    (operand_val),
    .subtrahend (acc_q),
    .diff       (diff),
    .borrow     (borrow)
  );

  assign jump_evt = npc_evt && opnd_is_pc;

  rssb_pc_step #(.ADDR_W(ADDR_W)) u_pc_step (
    .pc          (pc_q),
    .borrow      (borrow_q),
    .jump        (opnd_is_pc),
    .jump_target (acc_q[ADDR_W-1:0]),
    .pc_next     (pc_next)
  );

  rssb_regs #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .START_PC (START_PC)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_opnd   (rdop_evt && !halt_word),
    .opnd_d    (instr_opnd),
    .ld_result (wb_evt),
    .result_d  (diff),
    .borrow_d  (borrow),
    .ld_pc     (npc_evt),
    .pc_d      (pc_next),
    .pc_q      (pc_q),
    .acc_q     (acc_q),
    .opnd_q    (opnd_q),
    .borrow_q  (borrow_q)
  );

  always_comb begin
    unique case (state_q)
      ST_READ_OPND:  mem_addr = instr_opnd;
      ST_WRITE_BACK: mem_addr = opnd_q;
      default:       mem_addr = pc_q;
    endcase
  end

  assign mem_we    = wb_evt && opnd_external;
  assign mem_wdata = diff;
  assign halted    = (state_q == ST_HALT);

endmodule

// File: rtl/rssb_core_chk.sv
module rssb_core_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              halted,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              fetch_evt,
  input logic              rdop_evt,
  input logic              wb_evt,
  input logic              npc_evt,
  input logic              halt_evt,
  input logic              jump_evt,
  input logic [ADDR_W-1:0] opnd_q,
  input logic [ADDR_W-1:0] pc_q,
  input logic [DATA_W-1:0] acc_q,
  input logic              borrow_q
);

  a_r2_fetch_then_read: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_evt |=> rdop_evt);

  a_r2_read_then_wb: assert property (@(posedge clk) disable iff (!rst_n)
    rdop_evt && !halt_evt |=> wb_evt);

  a_r2_wb_then_npc: assert property (@(posedge clk) disable iff (!rst_n)
    wb_evt |=> npc_evt);

  a_r2_npc_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    npc_evt |=> fetch_evt);

  a_r4_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    npc_evt && !jump_evt |=>
      (pc_q - $past(pc_q)) == ($past(borrow_q) ? ADDR_W'(2) : ADDR_W'(1)));

  a_r5_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
    jump_evt |=> pc_q == $past(acc_q[ADDR_W-1:0]));

  a_r6_acc_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    wb_evt && (opnd_q == ADDR_W'(1)) |=> (acc_q == '0) && !borrow_q);

  a_r7_halt_entry: assert property (@(posedge clk) disable iff (!rst_n)
    halt_evt |=> halted);

  a_r7_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && !mem_we);

  a_r9_write_window: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> wb_evt && (mem_addr >= ADDR_W'(2)));

endmodule

bind rssb_core rssb_core_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .halted    (halted),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .fetch_evt (fetch_evt),
  .rdop_evt  (rdop_evt),
  .wb_evt    (wb_evt),
  .npc_evt   (npc_evt),
  .halt_evt  (halt_evt),
  .jump_evt  (jump_evt),
  .opnd_q    (opnd_q),
  .pc_q      (pc_q),
  .acc_q     (acc_q),
  .borrow_q  (borrow_q)
);

// File: tb/rssb_core_tb.sv
module rssb_core_tb;

  localparam int DW   = 8;
  localparam int AW   = 6;
  localparam int MW   = 64;
  localparam int SPC  = 2;
  localparam logic [DW-1:0] HALTW = 8'hFF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] mem_addr;
  logic          mem_we;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;
  logic          halted;

  always #2 clk = ~clk;

  logic [DW-1:0] tmem [MW];
  always @(posedge clk) begin
    mem_rdata <= tmem[mem_addr];
    if (mem_we) tmem[mem_addr] <= mem_wdata;
  end

  rssb_core #(.DATA_W(DW), .ADDR_W(AW), .START_PC(SPC)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .halted    (halted)
  );

  int total = 0;
  int bad   = 0;

  logic [DW-1:0] img  [MW];
  logic [DW-1:0] mmem [MW];
  int mpc;
  int macc;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_img();
    for (int i = 0; i < MW; i++) img[i] = (i < 40) ? HALTW : 8'h00;
  endtask

  task automatic run_prog();
    int    m, op, diff, instr;
    bit    brw, done;
    string tag;
    rst_n = 1'b0;
    @(negedge clk);
    for (int i = 0; i < MW; i++) begin
      tmem[i] = img[i];
      mmem[i] = img[i];
    end
    @(negedge clk);
    chk(!halted && !mem_we && mem_addr == AW'(SPC), "R1", "outputs in reset",
        int'(mem_addr), SPC);
    @(negedge clk);
    rst_n = 1'b1;
    chk(!halted && !mem_we, "R1", "halted/we after release",
        int'({halted, mem_we}), 0);
    mpc  = SPC;
    macc = 0;
    tag  = "R1";
    done = 1'b0;
    for (int n = 0; n < 64; n++) begin
      instr = int'(mmem[mpc]);
      chk(mem_addr == AW'(mpc), tag, "fetch address", int'(mem_addr), mpc);
      chk(!mem_we, "R9", "write in fetch cycle", int'(mem_we), 0);
      @(negedge clk);
      if (instr == int'(HALTW)) begin
        @(negedge clk);
        chk(halted, "R7", "halted after stop word", int'(halted), 1);
        for (int k = 0; k < 6; k++) begin
          @(negedge clk);
          chk(halted && !mem_we, "R7", "stays halted without writes",
              int'({halted, mem_we}), 2);
        end
        done = 1'b1;
        break;
      end
      m = instr % MW;
      chk(mem_addr == AW'(m), "R2", "operand address", int'(mem_addr), m);
      if (m == 0)      op = mpc;
      else if (m == 1) op = macc;
      else             op = int'(mmem[m]);
      diff = (op - macc + 256) % 256;
      brw  = (op < macc);
      @(negedge clk);
      chk(!halted, "R7", "not halted on normal word", int'(halted), 0);
      if (m >= 2) begin
        chk(mem_we && mem_addr == AW'(m) && mem_wdata == DW'(diff), "R3",
            "write-back data", int'(mem_wdata), diff);
        mmem[m] = DW'(diff);
      end else begin
        chk(!mem_we, (m == 0) ? "R5" : "R6", "no external write for alias",
            int'(mem_we), 0);
      end
      macc = diff;
      if (m == 0) begin
        mpc = diff % MW;
        tag = "R5";
      end else begin
        mpc = (mpc + (brw ? 2 : 1)) % MW;
        tag = (m == 1) ? "R6" : (brw ? "R4" : "R2");
      end
      @(negedge clk);
      @(negedge clk);
    end
    chk(done, "R7", "program reached stop word", int'(done), 1);
    begin
      int bad_i;
      bad_i = -1;
      for (int i = 0; i < MW; i++)
        if (tmem[i] != mmem[i] && bad_i < 0) bad_i = i;
      chk(bad_i < 0, "R3", "final memory image",
          (bad_i < 0) ? 0 : int'(tmem[bad_i]),
          (bad_i < 0) ? 0 : int'(mmem[bad_i]));
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R3 R4: sweep of accumulator and operand values with a skip candidate
    for (int x = 0; x < 256; x += 15) begin
      for (int y = 0; y < 256; y += 15) begin
        clear_img();
        img[2] = 8'd40; img[3] = 8'd40; img[4] = 8'd40;
        img[5] = 8'd41; img[6] = 8'd42; img[7] = 8'd43; img[8] = 8'd44;
        img[40] = 8'h5A; img[41] = DW'(x); img[42] = DW'(y);
        img[43] = 8'h33; img[44] = 8'h07;
        run_prog();
      end
    end
    // R6: operand address 1 clears the accumulator
    for (int x = 1; x < 256; x += 50) begin
      clear_img();
      img[2] = 8'd40; img[3] = 8'd40; img[4] = 8'd40;
      img[5] = 8'd41; img[6] = 8'd1; img[7] = 8'd42;
      img[40] = 8'h11; img[41] = DW'(x); img[42] = 8'h6C;
      run_prog();
      chk(tmem[42] == 8'h6C, "R6", "value after clear is unchanged",
          int'(tmem[42]), 'h6C);
    end
    // R5: backward jump, then skip chain
    clear_img();
    img[2] = 8'd40; img[3] = 8'd40; img[4] = 8'd40;
    img[5] = 8'd45; img[6] = 8'd0;
    img[45] = 8'd3;
    run_prog();
    chk(tmem[45] == 8'd6, "R5", "location after jump loop", int'(tmem[45]), 6);
    // R5: jump overrides borrow skip, with and without truncation
    for (int v = 0; v < 2; v++) begin
      clear_img();
      img[2] = 8'd40; img[3] = 8'd40; img[4] = 8'd40;
      img[5] = 8'd48; img[6] = 8'd0;
      img[48] = (v == 0) ? 8'hF0 : 8'hC5;
      run_prog();
    end
    // R8: triple clear of a scratch location from a loaded accumulator
    for (int x = 0; x < 256; x += 37) begin
      clear_img();
      img[2] = 8'd41; img[3] = 8'd46; img[4] = 8'd46; img[5] = 8'd46;
      img[6] = 8'd47;
      img[41] = DW'(x); img[46] = 8'h9C; img[47] = 8'h2D;
      run_prog();
      chk(tmem[46] == 8'h00, "R8", "scratch cleared", int'(tmem[46]), 0);
      chk(tmem[47] == 8'h2D, "R8", "accumulator cleared", int'(tmem[47]), 'h2D);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule